// File: doc/BRIEF.md
# Flow-Controlled Serial Character Receiver

This block turns an asynchronous serial line into parallel characters. A programmable 16-bit divider sets an oversampling tick at sixteen times the baud rate. The receiver finds each start bit, samples every bit at its centre and assembles a character of seven or eight data bits. A character may carry an optional odd or even parity bit and ends with one or two stop bits.

Each finished character enters a one-character holding register. If the holding register is still occupied, the character waits in a pending slot until the CPU reads. The CPU takes a character with a single-cycle read strobe. A registered interrupt pulse marks each character that enters the holding register, and a mask bit can suppress it. An active-low receive-enable output tells the far transmitter to pause once both the holding register and the pending slot are occupied.

Configuration comes through three write strobes that share a byte-wide data bus. The first writes the low divider byte, the second the high divider byte, and the third the character format. A fourth strobe writes the interrupt mask.

Top module: `uart_rx_fc`

## Requirements
- R1: The oversampling tick occurs once every (D+1) clock cycles, where D is the 16-bit divider; `div_lo_we` loads D[7:0] and `div_hi_we` loads D[15:8] from `wdata`. One bit time is 16 ticks.
- R2: The first data bit received lands in `rx_data[0]`. With format bit 0 = 1 a character has 8 data bits; with bit 0 = 0 it has 7 and `rx_data[7]` reads 0.
- R3: Format bit 1 = 1 adds a parity bit after the data bits, and format bit 2 selects odd (1) or even (0) parity. `par_err` is 1 for a character whose parity bit does not match.
- R4: `frm_err` is 1 for a character whose first stop bit samples low. Format bit 3 = 1 selects two stop bits; the second stop bit is not checked.
- R5: A character with a parity or framing error is still placed in the holding register, and the next character is received normally.
- R6: A character enters the holding register only when it is empty; otherwise it waits in the pending slot. A read strobe while `rx_full` is 1 clears `rx_full`, or refills the holding register from the pending slot on the next cycle.
- R7: `rx_irq` pulses for one cycle, together with `rx_full`, each time a character enters the holding register, errored or not, unless the mask bit (`wdata[0]` written with `mask_we`) is 1.
- R8: `rx_en_n` is 1 only while both the holding register and the pending slot are occupied, and 0 otherwise.
- R9: If a character completes while both the holding register and the pending slot are occupied, it is dropped and `ovr_err` becomes 1 until the next read strobe.
- R10: After a line break (the line stays low past the stop bit), no new character starts until the line has gone high and then falls again.
- R11: A low pulse on `rxd` that is high again at the centre of the start bit (tick 8) starts no character.
- R12: After reset, `rx_full`, `rx_irq`, `rx_en_n`, all error flags, `rx_data`, the format and the mask are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rxd | input | 1 | Serial receive line, idle high |
| div_lo_we | input | 1 | Write `wdata` into divider low byte |
| div_hi_we | input | 1 | Write `wdata` into divider high byte |
| cfg_we | input | 1 | Write `wdata[3:0]` into format register |
| mask_we | input | 1 | Write `wdata[0]` into receive interrupt mask |
| wdata | input | 8 | Write data |
| rd_strobe | input | 1 | Read pulse that pops the holding register |
| rx_data | output | 8 | Holding register character |
| rx_full | output | 1 | Holding register occupied |
| par_err | output | 1 | Parity error of held character |
| frm_err | output | 1 | Framing error of held character |
| ovr_err | output | 1 | Character lost to overrun |
| rx_irq | output | 1 | Receive interrupt pulse |
| rx_en_n | output | 1 | Active-low receive enable for flow control |

## Verification
The hardest state to reach is the one where both storage stages are occupied and a third character then arrives. In that state the flow-control output is raised, overrun is flagged, and a read moves the pending character forward. The bench reaches it by sending three frames back to back without reading, then reads twice and checks the order of the data and the interrupt pulses. The break case is another that ports alone do not easily reach. The bench holds the line low for several character times after a frame with a low stop bit, and only then releases the line and sends a new frame.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;
  localparam int DATA_W = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PAR,
    ST_STOP1,
    ST_STOP2
  } rx_state_e;

  typedef struct packed {
    logic two_stop;
    logic par_odd;
    logic par_en;
    logic eight;
  } rx_cfg_t;

  typedef struct packed {
    logic [DATA_W-1:0] data;
    logic              perr;
    logic              ferr;
  } rx_char_t;
endpackage

// File: rtl/uart_rx_baud.sv
module uart_rx_baud #(
  parameter int DIV_W = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       lo_we,
  input  logic       hi_we,
  input  logic [7:0] wdata,
  output logic       tick
);
  localparam int HI_W = DIV_W - 8;

  logic [DIV_W-1:0] div_q, div_n;
  logic [DIV_W-1:0] cnt_q, cnt_n;

  always_comb begin
    div_n = div_q;
    if (lo_we) div_n[7:0] = wdata;
    if (hi_we) div_n[DIV_W-1:8] = wdata[HI_W-1:0];
  end

  // Down-counter: tick on zero, then reload with the divider
  always_comb begin
    tick  = (cnt_q == '0);
    cnt_n = tick ? div_q : cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q <= '0;
      cnt_q <= '0;
    end else begin
      div_q <= div_n;
      cnt_q <= cnt_n;
    end
  end
endmodule

// File: rtl/uart_rx_shifter.sv
module uart_rx_shifter
  import uart_rx_pkg::*;
#(
  parameter int OVS = 16
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     tick,
  input  logic     rx_in,
  input  logic     rx_fell,
  input  rx_cfg_t  cfg,
  output logic     done,
  output rx_char_t chr
);
  localparam int CNT_W = $clog2(OVS);
  localparam logic [CNT_W-1:0] MID_T  = CNT_W'(OVS / 2 - 1);
  localparam logic [CNT_W-1:0] LAST_T = CNT_W'(OVS - 1);

  rx_state_e         st_q, st_n;
  logic [CNT_W-1:0]  tcnt_q, tcnt_n;
  logic [2:0]        bidx_q, bidx_n;
  logic [DATA_W-1:0] sh_q, sh_n;
  logic              par_q, par_n;
  logic              perr_q, perr_n;
  logic              ferr_q, ferr_n;
  logic              done_q, done_n;
  logic              sample;
  logic [2:0]        last_bit;

  always_comb begin
    sample   = tick && (tcnt_q == ((st_q == ST_START) ? MID_T : LAST_T));
    last_bit = cfg.eight ? 3'(DATA_W - 1) : 3'(DATA_W - 2);
  end

  always_comb begin
    st_n   = st_q;
    tcnt_n = tcnt_q;
    bidx_n = bidx_q;
    sh_n   = sh_q;
    par_n  = par_q;
    perr_n = perr_q;
    ferr_n = ferr_q;
    done_n = 1'b0;
    if (st_q != ST_IDLE && tick) tcnt_n = sample ? '0 : tcnt_q + 1'b1;
    case (st_q)
      ST_IDLE: begin
        // Only a real high-to-low transition arms a new frame
        if (rx_fell) begin
          st_n   = ST_START;
          tcnt_n = '0;
        end
      end
      ST_START: begin
        if (sample) begin
          if (rx_in) begin
            st_n = ST_IDLE;
          end else begin
            st_n   = ST_DATA;
            bidx_n = '0;
            sh_n   = '0;
            par_n  = 1'b0;
            perr_n = 1'b0;
            ferr_n = 1'b0;
          end
        end
      end
      ST_DATA: begin
        if (sample) begin
          sh_n   = {rx_in, sh_q[DATA_W-1:1]};
          par_n  = par_q ^ rx_in;
          bidx_n = bidx_q + 1'b1;
          if (bidx_q == last_bit) st_n = cfg.par_en ? ST_PAR : ST_STOP1;
        end
      end
      ST_PAR: begin
        if (sample) begin
          perr_n = ((par_q ^ rx_in) != cfg.par_odd);
          st_n   = ST_STOP1;
        end
      end
      ST_STOP1: begin
        if (sample) begin
          ferr_n = ~rx_in;
          if (cfg.two_stop) begin
            st_n = ST_STOP2;
          end else begin
            st_n   = ST_IDLE;
            done_n = 1'b1;
          end
        end
      end
      ST_STOP2: begin
        if (sample) begin
          st_n   = ST_IDLE;
          done_n = 1'b1;
        end
      end
      default: st_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      tcnt_q <= '0;
      bidx_q <= '0;
      sh_q   <= '0;
      par_q  <= 1'b0;
      perr_q <= 1'b0;
      ferr_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_n;
      tcnt_q <= tcnt_n;
      bidx_q <= bidx_n;
      sh_q   <= sh_n;
      par_q  <= par_n;
      perr_q <= perr_n;
      ferr_q <= ferr_n;
      done_q <= done_n;
    end
  end

  // 7-bit characters sit one place high in the shifter
  always_comb begin
    done      = done_q;
    chr.data  = cfg.eight ? sh_q : {1'b0, sh_q[DATA_W-1:1]};
    chr.perr  = perr_q;
    chr.ferr  = ferr_q;
  end
endmodule

// File: rtl/uart_rx_hold.sv
module uart_rx_hold
  import uart_rx_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     done,
  input  rx_char_t chr_in,
  input  logic     rd,
  input  logic     mask,
  output rx_char_t hold,
  output logic     full,
  output logic     pend_v,
  output logic     ovr,
  output logic     irq
);
  rx_char_t hold_q, hold_n, pend_q, pend_n;
  logic     full_q, full_n, pendv_q, pendv_n, ovr_q, ovr_n, irq_q, irq_n;
  logic     take, load;

  always_comb begin
    take    = rd & full_q;
    hold_n  = hold_q;
    pend_n  = pend_q;
    full_n  = full_q;
    pendv_n = pendv_q;
    ovr_n   = ovr_q;
    load    = 1'b0;
    if (take) begin
      ovr_n = 1'b0;
      if (pendv_q) begin
        hold_n  = pend_q;
        load    = 1'b1;
        pendv_n = 1'b0;
        if (done) begin
          pend_n  = chr_in;
          pendv_n = 1'b1;
        end
      end else if (done) begin
        hold_n = chr_in;
        load   = 1'b1;
      end else begin
        full_n = 1'b0;
      end
    end else if (!full_q) begin
      if (done) begin
        hold_n = chr_in;
        full_n = 1'b1;
        load   = 1'b1;
      end
    end else if (done) begin
      if (!pendv_q) begin
        pend_n  = chr_in;
        pendv_n = 1'b1;
      end else begin
        ovr_n = 1'b1;
      end
    end
    irq_n = load & ~mask;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q  <= '0;
      pend_q  <= '0;
      full_q  <= 1'b0;
      pendv_q <= 1'b0;
      ovr_q   <= 1'b0;
      irq_q   <= 1'b0;
    end else begin
      hold_q  <= hold_n;
      pend_q  <= pend_n;
      full_q  <= full_n;
      pendv_q <= pendv_n;
      ovr_q   <= ovr_n;
      irq_q   <= irq_n;
    end
  end

  always_comb begin
    hold   = hold_q;
    full   = full_q;
    pend_v = pendv_q;
    ovr    = ovr_q;
    irq    = irq_q;
  end
endmodule

// File: rtl/uart_rx_fc.sv
module uart_rx_fc
  import uart_rx_pkg::*;
#(
  parameter int DIV_W = 16,
  parameter int OVS   = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rxd,
  input  logic              div_lo_we,
  input  logic              div_hi_we,
  input  logic              cfg_we,
  input  logic              mask_we,
  input  logic [7:0]        wdata,
  input  logic              rd_strobe,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_full,
  output logic              par_err,
  output logic              frm_err,
  output logic              ovr_err,
  output logic              rx_irq,
  output logic              rx_en_n
);
  localparam int CFG_W = $bits(rx_cfg_t);

  logic     rst_meta, rst_sync_n;
  logic     rx_s1, rx_s2, rx_prev, rx_fell;
  rx_cfg_t  cfg_q, cfg_n;
  logic     mask_q, mask_n;
  logic     tick, chr_done, pend_v;
  rx_char_t chr, hold;
  logic     unused_wbits;

  assign unused_wbits = ^wdata[7:CFG_W];

  // Reset: asserted asynchronously, released on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta   <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta   <= 1'b1;
      rst_sync_n <= rst_meta;
    end
  end

  always_comb begin
    cfg_n  = cfg_we  ? rx_cfg_t'(wdata[CFG_W-1:0]) : cfg_q;
    mask_n = mask_we ? wdata[0] : mask_q;
    rx_fell = rx_prev & ~rx_s2;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      cfg_q   <= '0;
      mask_q  <= 1'b0;
      rx_s1   <= 1'b1;
      rx_s2   <= 1'b1;
      rx_prev <= 1'b1;
    end else begin
      cfg_q   <= cfg_n;
      mask_q  <= mask_n;
      rx_s1   <= rxd;
      rx_s2   <= rx_s1;
      rx_prev <= rx_s2;
    end
  end

  uart_rx_baud #(.DIV_W(DIV_W)) u_baud (
    .clk  (clk),
    .rst_n(rst_sync_n),
    .lo_we(div_lo_we),
    .hi_we(div_hi_we),
    .wdata(wdata),
    .tick (tick)
  );

  uart_rx_shifter #(.OVS(OVS)) u_shift (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .tick   (tick),
    .rx_in  (rx_s2),
    .rx_fell(rx_fell),
    .cfg    (cfg_q),
    .done   (chr_done),
    .chr    (chr)
  );

  uart_rx_hold u_hold (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .done  (chr_done),
    .chr_in(chr),
    .rd    (rd_strobe),
    .mask  (mask_q),
    .hold  (hold),
    .full  (rx_full),
    .pend_v(pend_v),
    .ovr   (ovr_err),
    .irq   (rx_irq)
  );

  always_comb begin
    rx_data = hold.data;
    par_err = hold.perr;
    frm_err = hold.ferr;
    rx_en_n = rx_full & pend_v;
  end
endmodule

// File: rtl/uart_rx_fc_chk.sv
module uart_rx_fc_chk (
  input logic clk,
  input logic rst_n,
  input logic rd_strobe,
  input logic rx_full,
  input logic rx_en_n,
  input logic rx_irq,
  input logic ovr_err,
  input logic rcv_mask,
  input logic done
);
  AST_FLOW_NEEDS_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    rx_en_n |-> rx_full); // R8
  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rcv_mask) |-> !rx_irq); // R7
  AST_IRQ_HAS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    rx_irq |-> rx_full); // R7
  AST_OVR_NEEDS_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovr_err) |-> $past(rx_en_n)); // R9
  AST_READ_DRAINS: assert property (@(posedge clk) disable iff (!rst_n)
    rd_strobe && rx_full && !rx_en_n && !done |=> !rx_full); // R6
  AST_READ_REFILLS: assert property (@(posedge clk) disable iff (!rst_n)
    rd_strobe && rx_en_n && !done |=> rx_full && !rx_en_n); // R6
endmodule

bind uart_rx_fc uart_rx_fc_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_sync_n),
  .rd_strobe(rd_strobe),
  .rx_full  (rx_full),
  .rx_en_n  (rx_en_n),
  .rx_irq   (rx_irq),
  .ovr_err  (ovr_err),
  .rcv_mask (mask_q),
  .done     (chr_done)
);

// File: tb/uart_rx_fc_test.sv
module uart_rx_fc_test;
  logic       clk = 1'b0;
  logic       rst_n, rxd, div_lo_we, div_hi_we, cfg_we, mask_we, rd_strobe;
  logic [7:0] wdata, rx_data;
  logic       rx_full, par_err, frm_err, ovr_err, rx_irq, rx_en_n;
  int         n_chk = 0;
  int         n_fail = 0;
  int         irq_cnt;

  always #10 clk = ~clk;

  uart_rx_fc uut (.*);

  always @(posedge clk or negedge rst_n)
    if (!rst_n) irq_cnt <= 0;
    else if (rx_irq) irq_cnt <= irq_cnt + 1;

  // {two_stop, odd, par_en, eight, flip_parity, bad_stop, 2'b0, data}
  localparam int NV = 7;
  localparam logic [15:0] VEC [NV] = '{
    16'h10A5, 16'h00C3, 16'h305A, 16'h7866, 16'h940F, 16'h60FF, 16'h3C81
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input int sel, input logic [7:0] v);
    @(negedge clk);
    wdata = v;
    div_lo_we = (sel == 0); div_hi_we = (sel == 1);
    cfg_we = (sel == 2);    mask_we = (sel == 3);
    @(negedge clk);
    {div_lo_we, div_hi_we, cfg_we, mask_we} = '0;
  endtask

  task automatic bit_out(input logic v, input int bitclk);
    rxd = v;
    repeat (bitclk) @(negedge clk);
  endtask

  task automatic send(input logic [7:0] d, input logic [3:0] cfg, input logic flip,
                      input logic bad, input logic brk, input int bitclk);
    int nb;
    logic p;
    nb = cfg[0] ? 8 : 7;
    @(negedge clk);
    bit_out(1'b0, bitclk);
    p = 1'b0;
    for (int i = 0; i < nb; i++) begin
      bit_out(d[i], bitclk);
      p ^= d[i];
    end
    if (cfg[1]) bit_out(p ^ cfg[2] ^ flip, bitclk);
    bit_out(~bad, bitclk);
    if (cfg[3]) bit_out(1'b1, bitclk);
    rxd = brk ? 1'b0 : 1'b1;
    repeat (bitclk) @(negedge clk);
  endtask

  task automatic rd();
    @(negedge clk);
    rd_strobe = 1'b1;
    @(negedge clk);
    rd_strobe = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    int i0;
    logic [3:0] c;
    logic [7:0] d;
    rst_n = 1'b0; rxd = 1'b1; wdata = '0; rd_strobe = 1'b0;
    {div_lo_we, div_hi_we, cfg_we, mask_we} = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R12 reset state
    chk("R12 full", rx_full, 0);
    chk("R12 irq", rx_irq, 0);
    chk("R12 en_n", rx_en_n, 0);
    chk("R12 flags", {par_err, frm_err, ovr_err}, 0);
    chk("R12 data", rx_data, 0);

    // Vector table: R2 R3 R4 R5 R7, divider 0 -> 16 clocks per bit
    for (int v = 0; v < NV; v++) begin
      c = VEC[v][15:12];
      d = VEC[v][7:0];
      i0 = irq_cnt;
      wr(2, {4'h0, c});
      send(d, c, VEC[v][11], VEC[v][10], 1'b0, 16);
      chk("R6 full", rx_full, 1);
      chk("R2 data", rx_data, c[0] ? d : {1'b0, d[6:0]});
      chk("R3 parity", par_err, VEC[v][11] & c[1]);
      chk("R4 framing", frm_err, VEC[v][10]);
      chk("R7 irq", irq_cnt - i0, 1);
      chk("R8 en_n", rx_en_n, 0);
      rd();
      chk("R6 drained", rx_full, 0);
    end

    // R7 masked interrupt
    wr(2, 8'h01);
    wr(3, 8'h01);
    i0 = irq_cnt;
    send(8'h96, 4'h1, 1'b0, 1'b0, 1'b0, 16);
    chk("R7 masked full", rx_full, 1);
    chk("R7 masked irq", irq_cnt - i0, 0);
    rd();
    wr(3, 8'h00);

    // R6 R8 R9: three characters with no read
    i0 = irq_cnt;
    send(8'h11, 4'h1, 1'b0, 1'b0, 1'b0, 16);
    chk("R8 one held", rx_en_n, 0);
    send(8'h22, 4'h1, 1'b0, 1'b0, 1'b0, 16);
    chk("R8 both held", rx_en_n, 1);
    chk("R6 first kept", rx_data, 8'h11);
    chk("R6 pending no irq", irq_cnt - i0, 1);
    send(8'h33, 4'h1, 1'b0, 1'b0, 1'b0, 16);
    chk("R9 overrun", ovr_err, 1);
    chk("R9 data kept", rx_data, 8'h11);
    rd();
    @(negedge clk);
    chk("R6 refill data", rx_data, 8'h22);
    chk("R6 refill full", rx_full, 1);
    chk("R8 released", rx_en_n, 0);
    chk("R9 cleared", ovr_err, 0);
    chk("R7 refill irq", irq_cnt - i0, 2);
    rd();
    chk("R9 third dropped", rx_full, 0);

    // R10 break then fresh edge
    send(8'h00, 4'h1, 1'b0, 1'b1, 1'b1, 16);
    repeat (64) @(negedge clk);
    chk("R10 break char", rx_full, 1);
    chk("R4 break framing", frm_err, 1);
    rd();
    repeat (160) @(negedge clk);
    chk("R10 no start in break", rx_full, 0);
    rxd = 1'b1;
    repeat (16) @(negedge clk);
    send(8'h3C, 4'h1, 1'b0, 1'b0, 1'b0, 16);
    chk("R10 after break", rx_data, 8'h3C);
    chk("R5 clean after error", frm_err, 0);
    rd();

    // R11 short glitch
    rxd = 1'b0;
    repeat (4) @(negedge clk);
    rxd = 1'b1;
    repeat (200) @(negedge clk);
    chk("R11 glitch", rx_full, 0);

    // R1 divider low byte: 3 clocks per tick
    wr(0, 8'h02);
    send(8'hC7, 4'h1, 1'b0, 1'b0, 1'b0, 48);
    chk("R1 div low", rx_full, 1);
    chk("R1 div data", rx_data, 8'hC7);
    rd();
    // R1 divider high byte: 259 clocks per tick, a 48-clock frame is missed
    wr(1, 8'h01);
    send(8'h55, 4'h1, 1'b0, 1'b0, 1'b0, 48);
    repeat (2400) @(negedge clk);
    chk("R1 div high", rx_full, 0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule